// File: doc/BRIEF.md
# Per-Crossing Trigger Frame Formatter

This block sits between up to six front-end trigger inputs and a word serializer. During each beam crossing it gathers the 16-bit trigger-primitive words that the input ports present, and when the crossing strobe marks the end of that crossing it turns the gathered words into one fixed-length frame. The frame is streamed out as 16-bit words with a valid flag and a start-of-frame flag, ready for a downstream serializer.

Every frame is 14 words long: a synchronisation marker, the number of the crossing the data belongs to, and twelve data slots. Slots with no data carry zero, so the downstream link sees a constant frame length whatever the trigger activity. If more than twelve words arrive in one crossing, the excess is dropped and a sticky flag records the loss.

Top module: `trig_frame_fmt`

## Requirements
- R1: After a synchronous active-low reset, `out_valid_o`, `out_sof_o` and `overflow_o` are 0, `out_data_o` is 0x0000, and the crossing numbering restarts at 0.
- R2: A crossing strobe sampled at clock edge k starts a frame whose first word is output from edge k+1; the frame is 14 words on 14 consecutive cycles with `out_valid_o` high, `out_sof_o` is high only with the first word, which is the marker 0xBC1D; with no frame in progress `out_valid_o` is 0 and `out_data_o` is 0x0000.
- R3: The second frame word is the crossing number: the count of crossing strobes accepted before the one that closed the crossing (the first frame after reset carries 0), held in 16 bits so that 65535 is followed by 0.
- R4: Words 3 to 14 are the twelve data slots, filled with the gathered words in order: words from an earlier cycle before words from a later cycle, and in one cycle the lower port index first; slots left unused are 0x0000.
- R5: Words past the twelfth in one crossing are discarded; the first discard sets `overflow_o`, which stays 1 until reset.
- R6: A word presented in the same cycle as the crossing strobe belongs to the crossing that the strobe opens, not to the frame the strobe closes.
- R7: Data on a port whose valid bit is low is ignored and occupies no slot.
- R8: With strobes exactly 14 cycles apart, frames follow each other with no gap: `out_valid_o` stays high and the next start-of-frame comes right after the previous fourteenth word.
- R9: A strobe arriving while a frame is still being sent abandons the rest of that frame; the new frame starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xing_i | input | 1 | Crossing strobe, one cycle per crossing boundary |
| in_valid_i | input | 6 | Per-port word valid, bit p for port p |
| in_data_i | input | 96 | Per-port 16-bit words, port p in bits [16p+15:16p] |
| out_valid_o | output | 1 | Frame word valid |
| out_sof_o | output | 1 | First word of a frame |
| out_data_o | output | 16 | Frame word |
| overflow_o | output | 1 | Sticky: a word was dropped for lack of a slot |

## Verification
The crossing strobe closes one crossing's collection and opens the next in the same cycle, and input words can arrive in that very cycle; the bench drives words on several ports together with the strobe and expects them in the following frame, never in the frame being captured. The strobe can also coincide with a frame still being sent, so the bench fires strobes mid-frame and finally on every cycle for a full wrap of the crossing number, judging every output cycle against a behavioural queue model of what the frame and its truncation must be.

// File: rtl/tff_pkg.sv
// Package: shared types for the per-crossing trigger frame formatter.
// Assumes 16-bit words throughout the frame.
package tff_pkg;
    localparam int unsigned TFF_WORD_W = 16;
    typedef logic [TFF_WORD_W-1:0] tff_word_t;
    localparam tff_word_t TFF_SYNC_DEFAULT = 16'hBC1D;
    typedef enum logic {TX_IDLE = 1'b0, TX_SEND = 1'b1} tff_tx_state_e;
endpackage

// File: rtl/tff_gather.sv
// Gathers valid words from all ports into a slot buffer for the current
// crossing. Within a cycle, lower ports take earlier slots. A strobe
// restarts the buffer, and the strobe cycle's own words open the new
// crossing. Words past MAX_SLOTS are dropped and flagged sticky.
// Assumes the frame transmitter snapshots slot_o/fill_o on the strobe.
module tff_gather #(
    parameter int unsigned NUM_PORTS = 6,
    parameter int unsigned MAX_SLOTS = 12,
    parameter int unsigned WORD_W    = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                xing_i,
    input  logic [NUM_PORTS-1:0]                in_valid_i,
    input  logic [NUM_PORTS*WORD_W-1:0]         in_data_i,
    output logic [MAX_SLOTS-1:0][WORD_W-1:0]    slot_o,
    output logic [$clog2(MAX_SLOTS+1)-1:0]      fill_o,
    output logic                                overflow_o
);
    localparam int unsigned FILL_W = $clog2(MAX_SLOTS + 1);
    localparam int unsigned SUM_W  = $clog2(MAX_SLOTS + NUM_PORTS + 1);

    logic [MAX_SLOTS-1:0][WORD_W-1:0] slot_nxt;
    logic [FILL_W-1:0]                fill_nxt;
    logic                             drop;

    // Place this cycle's words after the current fill, or from slot 0 on a strobe.
    always_comb begin
        logic [SUM_W-1:0] pos;
        slot_nxt = slot_o;
        drop     = 1'b0;
        pos      = xing_i ? '0 : SUM_W'(fill_o);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (in_valid_i[p]) begin
                if (pos < SUM_W'(MAX_SLOTS)) begin
                    for (int s = 0; s < MAX_SLOTS; s++) begin
                        if (pos == SUM_W'(s)) begin
                            slot_nxt[s] = in_data_i[p*WORD_W +: WORD_W];
                        end
                    end
                end else begin
                    drop = 1'b1;
                end
                pos = pos + 1'b1;
            end
        end
        fill_nxt = (pos > SUM_W'(MAX_SLOTS)) ? FILL_W'(MAX_SLOTS) : FILL_W'(pos);
    end

    // Register the slot buffer, fill level and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_o     <= '0;
            fill_o     <= '0;
            overflow_o <= 1'b0;
        end else begin
            slot_o     <= slot_nxt;
            fill_o     <= fill_nxt;
            overflow_o <= overflow_o | drop;
        end
    end

    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= FILL_W'(MAX_SLOTS));
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
    assert_new_xing_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xing_i && !(|in_valid_i)) |=> (fill_o == '0));
    assert_invalid_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!xing_i && !(|in_valid_i)) |=> $stable(fill_o));
endmodule

// File: rtl/tff_xing_ctr.sv
// Crossing number counter: advances once per strobe and wraps at its width.
// Its value before a strobe is the number of the crossing that strobe closes.
module tff_xing_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xing_i,
    output logic [CNT_W-1:0] xnum_o
);
    // Count strobes, natural wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xnum_o <= '0;
        end else if (xing_i) begin
            xnum_o <= xnum_o + 1'b1;
        end
    end

    assert_xnum_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !xing_i |=> $stable(xnum_o));
endmodule

// File: rtl/tff_frame_tx.sv
// Snapshots the gathered slots and crossing number on a strobe and sends
// the frame as marker, number, then MAX_SLOTS data words, one per cycle.
// Slots past the fill level are sent as zero. A strobe during sending
// restarts with the new frame. Assumes slots/fill are the closing crossing's.
module tff_frame_tx
    import tff_pkg::*;
#(
    parameter int unsigned MAX_SLOTS = 12,
    parameter int unsigned WORD_W    = 16,
    parameter logic [WORD_W-1:0] SYNC_WORD = WORD_W'(TFF_SYNC_DEFAULT)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             xing_i,
    input  logic [MAX_SLOTS-1:0][WORD_W-1:0] slot_i,
    input  logic [$clog2(MAX_SLOTS+1)-1:0]   fill_i,
    input  logic [WORD_W-1:0]                xnum_i,
    output logic                             out_valid_o,
    output logic                             out_sof_o,
    output logic [WORD_W-1:0]                out_data_o
);
    localparam int unsigned FILL_W    = $clog2(MAX_SLOTS + 1);
    localparam int unsigned FRAME_LEN = MAX_SLOTS + 2;
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0][WORD_W-1:0] frm_q;
    logic [FRAME_LEN-1:0][WORD_W-1:0] frm_cap;
    logic [IDX_W-1:0]                 idx_q;
    tff_tx_state_e                    state_q;

    // Header words of the captured frame.
    always_comb begin
        frm_cap[0] = SYNC_WORD;
        frm_cap[1] = xnum_i;
    end

    // Data slots of the captured frame, masked past the fill level.
    for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_cap
        always_comb begin
            frm_cap[s+2] = (FILL_W'(s) < fill_i) ? slot_i[s] : '0;
        end
    end

    // Capture on strobe, then step through the frame one word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q   <= '0;
            idx_q   <= '0;
            state_q <= TX_IDLE;
        end else if (xing_i) begin
            frm_q   <= frm_cap;
            idx_q   <= '0;
            state_q <= TX_SEND;
        end else if (state_q == TX_SEND) begin
            if (idx_q == LAST_IDX) begin
                idx_q   <= '0;
                state_q <= TX_IDLE;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Output word selection.
    always_comb begin
        out_valid_o = (state_q == TX_SEND);
        out_sof_o   = (state_q == TX_SEND) && (idx_q == '0);
        out_data_o  = (state_q == TX_SEND) ? frm_q[idx_q] : '0;
    end

    assert_sof_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof_o |-> (out_valid_o && out_data_o == SYNC_WORD));
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (out_data_o == '0 && !out_sof_o));
    assert_sof_then_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof_o && !xing_i) |=> (out_valid_o && !out_sof_o));
endmodule

// File: rtl/trig_frame_fmt.sv
// Top: per-crossing trigger frame formatter. Gathers words from NUM_PORTS
// inputs per crossing and emits one fixed-length frame per crossing strobe,
// during the following crossing. Assumes strobes are single-cycle pulses.
module trig_frame_fmt
    import tff_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 6,
    parameter int unsigned MAX_SLOTS = 12,
    parameter int unsigned WORD_W    = TFF_WORD_W,
    parameter logic [WORD_W-1:0] SYNC_WORD = WORD_W'(TFF_SYNC_DEFAULT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        xing_i,
    input  logic [NUM_PORTS-1:0]        in_valid_i,
    input  logic [NUM_PORTS*WORD_W-1:0] in_data_i,
    output logic                        out_valid_o,
    output logic                        out_sof_o,
    output logic [WORD_W-1:0]           out_data_o,
    output logic                        overflow_o
);
    localparam int unsigned FILL_W = $clog2(MAX_SLOTS + 1);

    logic [MAX_SLOTS-1:0][WORD_W-1:0] slot_w;
    logic [FILL_W-1:0]                fill_w;
    logic [WORD_W-1:0]                xnum_w;

    tff_gather #(
        .NUM_PORTS(NUM_PORTS), .MAX_SLOTS(MAX_SLOTS), .WORD_W(WORD_W)
    ) u_gather (
        .clk(clk), .rst_n(rst_n), .xing_i(xing_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .slot_o(slot_w), .fill_o(fill_w), .overflow_o(overflow_o)
    );

    tff_xing_ctr #(.CNT_W(WORD_W)) u_xctr (
        .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .xnum_o(xnum_w)
    );

    tff_frame_tx #(
        .MAX_SLOTS(MAX_SLOTS), .WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .xing_i(xing_i),
        .slot_i(slot_w), .fill_i(fill_w), .xnum_i(xnum_w),
        .out_valid_o(out_valid_o), .out_sof_o(out_sof_o), .out_data_o(out_data_o)
    );

    assert_strobe_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xing_i |=> out_sof_o);
    assert_number_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof_o && !xing_i) |=> (out_valid_o && out_data_o == xnum_w - 1'b1));
endmodule

// File: tb/trig_frame_fmt_test.sv
module trig_frame_fmt_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam int NS = 12;
    localparam int FL = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xing = 1'b0;
    logic [NP-1:0]    vld = '0;
    logic [NP*16-1:0] dat = '0;
    logic        out_valid, out_sof, overflow;
    logic [15:0] out_data;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    string scen = "R1";

    // model state
    int q[$];
    int frm[FL];
    int idx = 0;
    bit active = 0;
    int num = 0;
    bit ovf = 0;
    int seq = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_frame_fmt uut (
        .clk(clk), .rst_n(rst_n), .xing_i(xing), .in_valid_i(vld), .in_data_i(dat),
        .out_valid_o(out_valid), .out_sof_o(out_sof), .out_data_o(out_data),
        .overflow_o(overflow)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s (scenario %s) actual=%0h expected=%0h", tag, scen, act, exp);
        end
    endtask

    // behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            q.delete(); active = 0; idx = 0; num = 0; ovf = 0;
        end else begin
            if (xing) begin
                frm[0] = 16'hBC1D;
                frm[1] = num;
                for (int s = 0; s < NS; s++) frm[s+2] = (s < q.size()) ? q[s] : 0;
                num = (num + 1) % 65536;
                q.delete();
                active = 1; idx = 0;
            end else if (active) begin
                idx++;
                if (idx == FL) begin active = 0; idx = 0; end
            end
            for (int p = 0; p < NP; p++) begin
                if (vld[p]) begin
                    if (q.size() < NS) q.push_back(int'(dat[p*16 +: 16]));
                    else ovf = 1;
                end
            end
        end
    end

    // compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (started) begin
            int ev, es, ed;
            string dtag;
            ev = active;
            es = active && idx == 0;
            ed = active ? frm[idx] : 0;
            dtag = (idx == 0) ? "R2 marker" : (idx == 1) ? "R3 number" : "R4 slot";
            check(out_valid == ev, "R2 valid", out_valid, ev);
            check(out_sof == es, "R2 sof", out_sof, es);
            check(int'(out_data) == ed, dtag, out_data, ed);
            check(overflow == ovf, "R5 overflow", overflow, ovf);
        end
    end

    task automatic step(input bit x, input logic [NP-1:0] m);
        @(negedge clk);
        xing = x;
        vld = m;
        for (int p = 0; p < NP; p++) begin
            dat[p*16 +: 16] = 16'(seq);
            seq = (seq % 60000) + 1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 valid", out_valid, 0);
        check(overflow == 1'b0, "R1 overflow", overflow, 0);
        check(out_data == 16'h0, "R1 data", out_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        scen = "R4";
        step(0, 6'b000101); step(0, 6'b110000); step(0, 6'b000010);
        step(1, '0); idle(16);

        scen = "R6";
        step(0, 6'b000011); step(1, 6'b101000); step(0, 6'b000001);
        idle(14); step(1, '0); idle(16);

        scen = "R7";
        step(0, 6'b000000); step(0, 6'b010000); step(0, 6'b000000);
        step(1, '0); idle(16);

        scen = "R8";
        for (int k = 0; k < 4; k++) begin
            step(1, 6'b000100);
            for (int i = 0; i < 13; i++) step(0, (i == 3) ? 6'b100001 : 6'b000000);
        end
        idle(16);

        scen = "R9";
        step(0, 6'b000111); step(1, 6'b001000); idle(4);
        step(1, 6'b000011); idle(6); step(1, '0); idle(16);

        scen = "R5";
        check(overflow == 1'b0, "R5 flag before loss", overflow, 0);
        step(0, 6'b111111); step(0, 6'b111111); step(0, 6'b000111);
        step(1, '0); idle(16);
        step(1, '0); idle(16);
        check(overflow == 1'b1, "R5 flag sticky", overflow, 1);

        scen = "R3";
        for (int i = 0; i < 65540; i++) step(1, (i % 7 == 0) ? 6'b000001 : 6'b000000);
        idle(16);
        step(1, '0); idle(16);

        scen = "R1";
        @(negedge clk); rst_n = 1'b0; xing = 0; vld = '0;
        @(negedge clk); @(negedge clk);
        #1;
        check(overflow == 1'b0, "R1 overflow cleared", overflow, 0);
        rst_n = 1'b1;
        step(1, '0); idle(16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog (scenario %s) actual=timeout expected=done", scen);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule